// File: doc/BRIEF.md
# Normalising Restoring Remainder Unit

This block takes an unsigned dividend and a nonzero unsigned divisor, both `DW` bits wide, and returns the remainder of their division. It does not produce a quotient. A one-cycle `start` pulse loads both operands. The unit then shifts the divisor left until its most significant data bit is set, and it counts the shifts as it goes.

After that it runs a series of trial subtractions on a signed partial remainder that is one bit wider than the data. Any subtraction that goes negative is undone by adding the divisor back. Between trials the divisor moves one place right, and the shift count runs down toward zero. When the count reaches zero and the last trial is resolved, `done` pulses for one clock. At that point the remainder and the restored divisor are on the outputs, and they stay there until the next accepted start.

One shared adder/shifter does all the arithmetic, one operation per clock. A controller sequences it and an up/down counter tracks the shifts. With `k` leading zeros in the divisor, the operation takes `4k+4` clocks after the start is captured.

Top module: `normrem_unit`

## Requirements
- R1: While `rst` is high and after it is released, `done` is 0 and `remainder` and `divisor_out` are all zeros.
- R2: For any dividend and any nonzero divisor, the `remainder` shown while `done` is high equals dividend modulo divisor, so it is always below the divisor.
- R3: While `done` is high, `divisor_out` equals the divisor loaded with the accepted start, after all normalising shifts have been undone.
- R4: `done` is high for exactly one clock per operation.
- R5: Let the start be captured at clock edge 0, and let k be the number of leading zero bits of the divisor. Then `done` rises at clock edge 4k+4: k+1 normalisation cycles followed by k+1 rounds of subtract, restore and shift.
- R6: A `start` raised while an operation is in progress is ignored: result and latency are those of the operation already running.
- R7: When the unit is idle and `start` is low, `remainder` and `divisor_out` hold their values.
- R8: Corner operands are handled: a dividend below the divisor returns the dividend, equal operands return 0, a zero dividend returns 0, and a divisor of 1 takes the longest run (k = DW-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled only while idle |
| dividend | input | DW | Unsigned dividend, captured with start |
| divisor | input | DW | Unsigned nonzero divisor, captured with start |
| done | output | 1 | One-clock pulse marking a valid result |
| remainder | output | DW | Remainder, registered |
| divisor_out | output | DW | Divisor register after restoration, registered |

## Verification
Several internal faults show up at the ports. A wrong shift count leaves `divisor_out` still shifted on the `done` cycle and moves `done` off the 4k+4 edge, so that single cycle shows both symptoms. A missed restore, or a restore applied to a positive remainder, gives a remainder that is too large or wraps, and this is visible the moment `done` rises. A controller that accepts a start while busy changes both the result and the latency of the operation under way. The random operand mix, together with the directed extremes (divisor 1, divisor with its top bit set, equal operands), makes every shift depth from 0 to 7 appear.

// File: rtl/normrem_pkg.sv
package normrem_pkg;

  // Arithmetic unit operation select; shifts act on the second operand.
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_SHL = 2'b10,
    OP_SHR = 2'b11
  } alu_op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_NORM = 3'd1,
    ST_SUB  = 3'd2,
    ST_CHK  = 3'd3,
    ST_STEP = 3'd4
  } ctrl_state_e;

endpackage

// File: rtl/normrem_alu.sv
module normrem_alu
  import normrem_pkg::*;
#(
  parameter int W = 9
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_SHL:  y = {b[W-2:0], 1'b0};
      OP_SHR:  y = {1'b0, b[W-1:1]};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/normrem_cnt.sv
module normrem_cnt #(
  parameter int CW  = 3,
  parameter int MAX = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          down,
  output logic [CW-1:0] value,
  output logic          is_zero,
  output logic          is_full
);

  localparam logic [CW-1:0] LIMIT = CW'(MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      value <= '0;
    end else if (en) begin
      if (down) value <= value - 1'b1;
      else      value <= value + 1'b1;
    end
  end

  assign is_zero = (value == '0);
  assign is_full = (value == LIMIT);

endmodule

// File: rtl/normrem_ctrl.sv
module normrem_ctrl
  import normrem_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        dv_top,
  input  logic        pr_neg,
  input  logic        cnt_zero,
  input  logic        cnt_full,
  output alu_op_e     op,
  output logic        load,
  output logic        pr_we,
  output logic        dv_we,
  output logic        cnt_clr,
  output logic        cnt_en,
  output logic        cnt_down,
  output logic        finish,
  output ctrl_state_e state
);

  ctrl_state_e nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    nxt      = state;
    op       = OP_ADD;
    load     = 1'b0;
    pr_we    = 1'b0;
    dv_we    = 1'b0;
    cnt_clr  = 1'b0;
    cnt_en   = 1'b0;
    cnt_down = 1'b0;
    finish   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          cnt_clr = 1'b1;
          nxt     = ST_NORM;
        end
      end
      ST_NORM: begin
        // shift left until the top data bit is set; the count limit stops a zero divisor
        if (!dv_top && !cnt_full) begin
          op     = OP_SHL;
          dv_we  = 1'b1;
          cnt_en = 1'b1;
        end else begin
          nxt = ST_SUB;
        end
      end
      ST_SUB: begin
        op    = OP_SUB;
        pr_we = 1'b1;
        nxt   = ST_CHK;
      end
      ST_CHK: begin
        if (pr_neg) begin
          op    = OP_ADD;
          pr_we = 1'b1;
        end
        nxt = ST_STEP;
      end
      ST_STEP: begin
        if (cnt_zero) begin
          finish = 1'b1;
          nxt    = ST_IDLE;
        end else begin
          op       = OP_SHR;
          dv_we    = 1'b1;
          cnt_en   = 1'b1;
          cnt_down = 1'b1;
          nxt      = ST_SUB;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/normrem_unit.sv
module normrem_unit
  import normrem_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [DW-1:0] remainder,
  output logic [DW-1:0] divisor_out
);

  localparam int RW = DW + 1;
  localparam int CW = (DW > 2) ? $clog2(DW) : 1;

  logic [RW-1:0] pr_q;
  logic [RW-1:0] dv_q;
  logic [RW-1:0] alu_y;
  logic [CW-1:0] cnt_val;
  alu_op_e       op;
  ctrl_state_e   st;
  logic load, pr_we, dv_we, cnt_clr, cnt_en, cnt_down, finish;
  logic cnt_zero, cnt_full;
  logic done_q;

  normrem_alu #(.W(RW)) u_alu (
    .a  (pr_q),
    .b  (dv_q),
    .op (op),
    .y  (alu_y)
  );

  normrem_cnt #(.CW(CW), .MAX(DW - 1)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (cnt_clr),
    .en      (cnt_en),
    .down    (cnt_down),
    .value   (cnt_val),
    .is_zero (cnt_zero),
    .is_full (cnt_full)
  );

  normrem_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .dv_top   (dv_q[DW-1]),
    .pr_neg   (pr_q[RW-1]),
    .cnt_zero (cnt_zero),
    .cnt_full (cnt_full),
    .op       (op),
    .load     (load),
    .pr_we    (pr_we),
    .dv_we    (dv_we),
    .cnt_clr  (cnt_clr),
    .cnt_en   (cnt_en),
    .cnt_down (cnt_down),
    .finish   (finish),
    .state    (st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pr_q   <= '0;
      dv_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (load)       pr_q <= {1'b0, dividend};
      else if (pr_we) pr_q <= alu_y;
      if (load)       dv_q <= {1'b0, divisor};
      else if (dv_we) dv_q <= alu_y;
    end
  end

  assign done        = done_q;
  assign remainder   = pr_q[DW-1:0];
  assign divisor_out = dv_q[DW-1:0];

endmodule

// File: rtl/normrem_checks.sv
module normrem_checks
  import normrem_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic [DW-1:0] remainder,
  input logic [DW-1:0] divisor_out,
  input ctrl_state_e   st,
  input logic [DW:0]   pr,
  input logic [DW:0]   dv
);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_rem_below_div_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (remainder < divisor_out));

  assert_restored_nonneg_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STEP) |-> !pr[DW]);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !start) |=> ($stable(remainder) && $stable(divisor_out)));

  assert_norm_top_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_NORM) |=> (st == ST_NORM || dv[DW-1]));

  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && st != ST_STEP) |=> (st != ST_IDLE));

endmodule

bind normrem_unit normrem_checks #(.DW(DW)) u_checks (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .done        (done),
  .remainder   (remainder),
  .divisor_out (divisor_out),
  .st          (st),
  .pr          (pr_q),
  .dv          (dv_q)
);

// File: tb/tb_normrem_unit.sv
module tb_normrem_unit;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] dividend = '0;
  logic [DW-1:0] divisor = '0;
  logic          done;
  logic [DW-1:0] remainder;
  logic [DW-1:0] divisor_out;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  normrem_unit #(.DW(DW)) dut (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .dividend    (dividend),
    .divisor     (divisor),
    .done        (done),
    .remainder   (remainder),
    .divisor_out (divisor_out)
  );

  function automatic int lead_zeros(input logic [DW-1:0] b);
    for (int i = DW - 1; i >= 0; i--) if (b[i]) return DW - 1 - i;
    return DW - 1;
  endfunction

  function automatic int exp_mod(input int a, input int b);
    return a % b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [DW-1:0] a, input logic [DW-1:0] b, input bit poke);
    int n;
    int exp_lat;
    logic [DW-1:0] r_hold;
    logic [DW-1:0] d_hold;
    exp_lat = 4 * lead_zeros(b) + 4;
    @(negedge clk);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      if (poke && n == 2) begin
        dividend = ~a;
        divisor  = 8'h01;
        start    = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (poke) check(n == exp_lat, "R6 latency with busy start", n, exp_lat);
    else      check(n == exp_lat, "R5 latency", n, exp_lat);
    check(remainder == DW'(exp_mod(a, b)), poke ? "R6 remainder" : "R2 remainder",
          remainder, exp_mod(a, b));
    check(divisor_out == b, "R3 restored divisor", divisor_out, b);
    r_hold = remainder;
    d_hold = divisor_out;
    @(negedge clk);
    check(done == 1'b0, "R4 done single cycle", done, 0);
    repeat (2) @(negedge clk);
    check(remainder == r_hold && divisor_out == d_hold, "R7 hold while idle",
          remainder, r_hold);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1 during and after reset
    check(done == 1'b0 && remainder == '0 && divisor_out == '0, "R1 in reset", remainder, 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && remainder == '0 && divisor_out == '0, "R1 after reset", remainder, 0);

    // R8 corner operands
    run_op(8'd15,  8'd24,  1'b0);  // dividend below divisor
    run_op(8'd77,  8'd77,  1'b0);  // equal operands
    run_op(8'd0,   8'd5,   1'b0);  // zero dividend
    run_op(8'd255, 8'd1,   1'b0);  // deepest normalisation
    run_op(8'd255, 8'd255, 1'b0);  // no normalisation
    run_op(8'd200, 8'd128, 1'b0);
    run_op(8'd24,  8'd15,  1'b0);
    run_op(8'd100, 8'd3,   1'b0);
    // R6 start while busy
    run_op(8'd250, 8'd7,   1'b1);
    run_op(8'd9,   8'd200, 1'b1);

    for (int i = 0; i < 300; i++) begin
      logic [DW-1:0] ra;
      logic [DW-1:0] rb;
      ra = DW'($urandom);
      rb = DW'($urandom);
      if (i % 4 == 0) rb = rb >> ($urandom % DW);
      if (rb == '0) rb = 8'd1;
      run_op(ra, rb, (i % 17) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule